// File: doc/BRIEF.md
# Serial Configuration Memory Read Sequencer

The block streams the contents of a small internal storage array out one bit per clock toward a device that is loading its configuration. A word counter and a bit counter walk through the stored words, most significant bit first, and stop at the last word of the active address range. The range is the whole array, or one of four equal partitions picked by a two-bit select when paging is switched on.

Several such blocks can be chained. When one block has finished its range, it pulls its chain-enable output low, and that output drives the chip enable of the next block. A combined reset/output-enable input restarts the read from the start of the active range. A serial-mode input, when low, puts the block in programming mode: the read logic is then frozen and the output driver is off.

Top module: `cfg_rd_seq`

## Requirements
- R1: With page_en_i high, the read covers only the partition picked by page_sel_i. For partition p the range starts at word p*DEPTH/4 and ends at word (p+1)*DEPTH/4-1, where DEPTH=2**ADDR_W. The default is 64 words, so each partition holds 16 words.
- R2: With page_en_i low, page_sel_i has no effect and the read covers words 0 to DEPTH-1.
- R3: With ser_en_i high and rst_oe_ni low at a rising edge, the word counter loads the start of the active range and the bit counter loads 0. The end state is cleared. ce_no is high while rst_oe_ni is low.
- R4: With ser_en_i high, ce_ni low and rst_oe_ni high, each rising edge moves the stream on by one bit. data_o shows bit W-1-b of the current word, where b is the bit count, so each word goes out MSB first. data_oe_o is high exactly under these conditions.
- R5: With ser_en_i high and ce_ni high, both counters hold, data_oe_o is low and standby_o is high.
- R6: Once the last bit of the top word of the range has been clocked out, both counters saturate and data_o stays at that last bit. ce_no is low while ce_ni is low and rst_oe_ni is high.
- R7: In the end state with rst_oe_ni high, ce_no equals ce_ni. A low on rst_oe_ni forces ce_no high, and ce_no stays high until the end of the range is reached again.
- R8: With ser_en_i low, neither counter changes, whatever the values on page_en_i, page_sel_i, ce_ni and rst_oe_ni. data_oe_o and standby_o are low and ce_no is high.
- R9: An active rst_ni clears the word counter to 0, the bit counter to 0 and the end state.
- R10: The stored word at address a is (a*PRE_MUL+PRE_ADD) mod 2**W. The defaults are 29 and 90, with W=8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counters move on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_en_i | input | 1 | High selects serial read mode; low selects programming mode |
| ce_ni | input | 1 | Chip enable, active low |
| rst_oe_ni | input | 1 | Low restarts the read; high enables the output |
| page_en_i | input | 1 | Turns partitioned addressing on |
| page_sel_i | input | 2 | Partition select |
| data_o | output | 1 | Serial data bit |
| data_oe_o | output | 1 | Output driver enable for data_o |
| ce_no | output | 1 | Chain-enable output for the next device, active low |
| standby_o | output | 1 | High while the block is idle in standby |

## Verification
The assertions take page_en_i and page_sel_i to change only in a cycle where rst_oe_ni is low. This keeps the word counter inside the active range, so the end of the range is always reached. The stimulus changes the page inputs only in cycles where it also drives a restart. Between restarts it varies ce_ni, rst_oe_ni and ser_en_i freely. While paging is off it scrambles page_sel_i, because that input should have no effect then.

// File: rtl/cfg_rd_pkg.sv
package cfg_rd_pkg;
  localparam int unsigned NUM_PAGES = 4;
  localparam int unsigned PAGE_SEL_W = 2;
endpackage

// File: rtl/cfg_rd_page_dec.sv
module cfg_rd_page_dec
  import cfg_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                  page_en_i,
  input  logic [PAGE_SEL_W-1:0] page_sel_i,
  output logic [ADDR_W-1:0]     start_o,
  output logic [ADDR_W-1:0]     top_o
);
  localparam int unsigned PART_W = ADDR_W - PAGE_SEL_W;

  always_comb begin
    if (page_en_i) begin
      start_o = {page_sel_i, {PART_W{1'b0}}};
      top_o   = {page_sel_i, {PART_W{1'b1}}};
    end else begin
      start_o = '0;
      top_o   = '1;
    end
  end
endmodule

// File: rtl/cfg_rd_counters.sv
module cfg_rd_counters #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned BIT_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] top_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              done_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      bit_o  <= '0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      addr_o <= start_i;
      bit_o  <= '0;
      done_o <= 1'b0;
    end else if (adv_i && !done_o) begin
      if (bit_o == LAST_BIT) begin
        if (addr_o == top_i) begin
          done_o <= 1'b1;           // saturate on the final bit
        end else begin
          addr_o <= addr_o + 1'b1;
          bit_o  <= '0;
        end
      end else begin
        bit_o <= bit_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_rd_store.sv
module cfg_rd_store #(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned PRE_MUL = 29,
  parameter int unsigned PRE_ADD = 90,
  localparam int unsigned BIT_W  = $clog2(WORD_W),
  localparam int unsigned DEPTH  = 2 ** ADDR_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              data_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [WORD_W-1:0] rom_q [DEPTH];

  initial begin
    for (int unsigned i = 0; i < DEPTH; i++) begin
      rom_q[i] = WORD_W'(i * PRE_MUL + PRE_ADD);
    end
  end

  logic [WORD_W-1:0] word;
  assign word   = rom_q[addr_i];
  assign data_o = word[LAST_BIT - bit_i];
endmodule

// File: rtl/cfg_rd_seq.sv
module cfg_rd_seq
  import cfg_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 6,
  parameter int unsigned WORD_W  = 8,
  parameter int unsigned PRE_MUL = 29,
  parameter int unsigned PRE_ADD = 90
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ser_en_i,
  input  logic                  ce_ni,
  input  logic                  rst_oe_ni,
  input  logic                  page_en_i,
  input  logic [PAGE_SEL_W-1:0] page_sel_i,
  output logic                  data_o,
  output logic                  data_oe_o,
  output logic                  ce_no,
  output logic                  standby_o
);
  localparam int unsigned BIT_W = $clog2(WORD_W);

  logic [ADDR_W-1:0] start, top, addr;
  logic [BIT_W-1:0]  bit_cnt;
  logic              done, clr, adv;

  assign clr = ser_en_i && !rst_oe_ni;
  assign adv = ser_en_i && rst_oe_ni && !ce_ni;

  cfg_rd_page_dec #(.ADDR_W(ADDR_W)) u_dec (
    .page_en_i (page_en_i),
    .page_sel_i(page_sel_i),
    .start_o   (start),
    .top_o     (top)
  );

  cfg_rd_counters #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .adv_i  (adv),
    .start_i(start),
    .top_i  (top),
    .addr_o (addr),
    .bit_o  (bit_cnt),
    .done_o (done)
  );

  cfg_rd_store #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .PRE_MUL(PRE_MUL), .PRE_ADD(PRE_ADD)
  ) u_store (
    .addr_i(addr),
    .bit_i (bit_cnt),
    .data_o(data_o)
  );

  // Cascade: after end of range, pass chip enable through while output is enabled
  assign ce_no     = (ser_en_i && done && rst_oe_ni) ? ce_ni : 1'b1;
  assign data_oe_o = adv;
  assign standby_o = ser_en_i && ce_ni;
endmodule

// File: rtl/cfg_rd_seq_chk.sv
module cfg_rd_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ser_en_i,
  input logic ce_ni,
  input logic rst_oe_ni,
  input logic data_o,
  input logic data_oe_o,
  input logic ce_no,
  input logic standby_o
);
  assert_oe_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (ser_en_i && !ce_ni && rst_oe_ni));

  assert_hold_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && ce_ni && rst_oe_ni) |=> $stable(data_o));

  assert_standby_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_o |-> !data_oe_o);

  assert_cascade_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |-> (ser_en_i && !ce_ni && rst_oe_ni));

  assert_clear_ceo_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_en_i && !rst_oe_ni) |=> ce_no);

  assert_prog_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |=> $stable(data_o));

  assert_prog_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_en_i |-> (!data_oe_o && ce_no && !standby_o));
endmodule

bind cfg_rd_seq cfg_rd_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ser_en_i (ser_en_i),
  .ce_ni    (ce_ni),
  .rst_oe_ni(rst_oe_ni),
  .data_o   (data_o),
  .data_oe_o(data_oe_o),
  .ce_no    (ce_no),
  .standby_o(standby_o)
);

// File: tb/cfg_rd_seq_tb_top.sv
module cfg_rd_seq_tb_top;
  localparam int unsigned ADDR_W  = 6;
  localparam int unsigned WORD_W  = 8;
  localparam int unsigned MULV    = 29;
  localparam int unsigned ADDV    = 90;
  localparam int unsigned DEPTH   = 2 ** ADDR_W;
  localparam int unsigned PART    = DEPTH / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b1, ce_n = 1'b1, rst_oe_n = 1'b1, page_en = 1'b0;
  logic [1:0] page_sel = 2'b00;
  logic data, data_oe, ceo_n, standby;

  int n_chk = 0, n_fail = 0;
  string cur_tag = "R4";
  string ceo_tag = "R6";

  int unsigned m_addr = 0, m_bit = 0;
  bit m_done = 1'b0;

  always #2 clk = ~clk;

  cfg_rd_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .PRE_MUL(MULV), .PRE_ADD(ADDV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_en_i(ser_en), .ce_ni(ce_n),
    .rst_oe_ni(rst_oe_n), .page_en_i(page_en), .page_sel_i(page_sel),
    .data_o(data), .data_oe_o(data_oe), .ce_no(ceo_n), .standby_o(standby)
  );

  function automatic logic [WORD_W-1:0] word_at(int unsigned a);  // R10
    return WORD_W'(a * MULV + ADDV);
  endfunction

  function automatic int unsigned range_lo(bit pe, logic [1:0] ps);
    return pe ? ps * PART : 0;
  endfunction

  function automatic int unsigned range_hi(bit pe, logic [1:0] ps);
    return pe ? ps * PART + PART - 1 : DEPTH - 1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(logic c, logic o, logic s, logic pe, logic [1:0] ps);
    logic [WORD_W-1:0] w;
    @(negedge clk);
    ce_n = c; rst_oe_n = o; ser_en = s; page_en = pe; page_sel = ps;
    #1;
    w = word_at(m_addr);
    check(cur_tag, data, w[WORD_W-1-m_bit]);
    check("R4", data_oe, s && !c && o);
    check("R5", standby, s && c);
    check(ceo_tag, ceo_n, (s && m_done && o) ? c : 1'b1);
    @(posedge clk);
    if (s) begin
      if (!o) begin
        m_addr = range_lo(pe, ps); m_bit = 0; m_done = 1'b0;
      end else if (!c && !m_done) begin
        if (m_bit == WORD_W - 1) begin
          if (m_addr == range_hi(pe, ps)) m_done = 1'b1;
          else begin m_addr++; m_bit = 0; end
        end else m_bit++;
      end
    end
  endtask

  task automatic read_range(bit pe, logic [1:0] ps);
    int unsigned n;
    n = (range_hi(pe, ps) - range_lo(pe, ps) + 1) * WORD_W;
    cyc(1'b0, 1'b0, 1'b1, pe, ps);                 // restart, R3
    for (int unsigned i = 0; i < n; i++)
      cyc(1'b0, 1'b1, 1'b1, pe, pe ? ps : 2'(i));  // page_sel scrambled when off, R2
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [WORD_W-1:0] w;
    void'($urandom(32'd7741));
    #7;
    // R9: reset state
    check("R9", ceo_n, 1'b1);
    w = word_at(0);
    check("R9", data, w[WORD_W-1]);
    rst_n = 1'b1;

    // R1 + R6 + R7 per partition
    for (int p = 0; p < 4; p++) begin
      cur_tag = "R1";
      read_range(1'b1, 2'(p));
      ceo_tag = "R6";
      cur_tag = "R6";
      repeat (3) cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'(p));
      w = word_at(p * PART + PART - 1);
      check("R6", data, w[0]);
      check("R6", ceo_n, 1'b0);
      ceo_tag = "R7";
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'(p));
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'(p));
      cyc(1'b1, 1'b1, 1'b1, 1'b1, 2'(p));
      cur_tag = "R3";
      cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'(p));
      cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'(p));
      check("R7", ceo_n, 1'b1);
      ceo_tag = "R6";
    end

    // R2: whole space, select ignored
    cur_tag = "R2";
    read_range(1'b0, 2'b10);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, 2'b01);
    check("R2", ceo_n, 1'b0);

    // R8: programming mode freezes the read
    cur_tag = "R8";
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 2'b01);
    repeat (5) cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'b01);
    for (int i = 0; i < 40; i++)
      cyc(1'($urandom), 1'($urandom), 1'b0, 1'($urandom), 2'($urandom));
    check("R8", data_oe, 1'b0);
    repeat (20) cyc(1'b0, 1'b1, 1'b1, 1'b1, 2'b01);

    // Random mix, R10 content across all words
    cur_tag = "R10";
    begin
      logic pe;
      logic [1:0] ps;
      pe = 1'b1; ps = 2'b01;
      for (int i = 0; i < 6000; i++) begin
        logic c, o, s;
        s = ($urandom % 100) >= 4;
        o = ($urandom % 100) >= 3;
        c = ($urandom % 100) < 20;
        if (s && !o) begin pe = 1'($urandom); ps = 2'($urandom); end
        cyc(c, o, s, pe, ps);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule